// File: doc/BRIEF.md
# Self-Looping Stream Iterator

This block runs one stream process whose result is fed back to its own input for a fixed number of rounds. An iteration counter starts at 1 and counts up to the parameter `N_ITER`. On each round a read stage picks a source token, an execute stage transforms it, and a write stage routes the result. Both the source and the destination are chosen from the counter value alone. The first round takes its token from the external input. Every later round takes it from an internal bounded FIFO that carries the previous result back. The final round sends its result to the external output. All earlier rounds push their result into that internal FIFO.

Every external port uses a valid/ready handshake. The stages are pipelined and pass tokens to each other through the same kind of handshake. Each stage waits whenever its source is empty or its destination cannot accept. A run is one token in and one token out. The execute function adds one modulo 2^16, so a token x entering a run leaves as x + `N_ITER`. When the result has been delivered, the block raises `done`, which stays high until reset. While `done` is high the external input stays closed.

Top module: `loopback_stream_proc`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` and `done` are 0 and `in_ready` is 1.
- R2: Each run accepts exactly one external input token. After that handshake, `in_ready` stays 0 until the next reset, whatever `in_valid` does.
- R3: Rounds 2 to `N_ITER` take their operand from the internal loop FIFO, which is never pushed when full and never popped when empty. With the output always ready, the first cycle with `out_valid` high comes 2*`N_ITER`-1 cycles after the cycle of the input handshake.
- R4: Each round computes its result as the operand plus 1, wrapping modulo 2^`DATA_W`. The external result of a run is therefore (x + `N_ITER`) mod 2^16 for the default width of 16.
- R5: Only the final round drives the external output. Each run presents exactly one output token, and `out_valid` falls after that token is accepted.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value on the next cycle.
- R7: `done` rises in the cycle after the output handshake and stays high until reset. `in_ready` is 0 whenever `done` is 1.
- R8: With `N_ITER` = 1, the single round reads the external input and writes the external output, and the result is x + 1.
- R9: No output is presented before an input token has been accepted. The block waits indefinitely while `in_valid` is 0.
- R10: The parameters are checked when the design is elaborated: `N_ITER` must be at least 1, `LOOP_DEPTH` at least 2, and `DATA_W` at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; starts a new run |
| in_valid | input | 1 | External input token is offered |
| in_ready | output | 1 | Block takes the external token this cycle |
| in_data | input | DATA_W | External input token |
| out_valid | output | 1 | Final result is offered |
| out_ready | input | 1 | Consumer accepts the result this cycle |
| out_data | output | DATA_W | Final result |
| done | output | 1 | Run complete; sticky until reset |

## Verification
The properties make no assumption about how `in_valid` or `out_ready` behave, apart from reset being applied first. They rely only on the block's own promise that a result held under back-pressure does not change. The stimulus drives inputs just after each rising edge and keeps `in_data` steady while it is offered. It also goes on raising `in_valid` after the one token has been taken, to show that the input stays closed. The output back-pressure patterns put stalls at every stage of the loop: before the input arrives, during the internal rounds, and while the final result waits to be accepted.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

   // Operand source chosen by the read stage from the iteration count
   typedef enum logic {
      SRC_EXT  = 1'b0,
      SRC_LOOP = 1'b1
   } src_sel_e;

   // Result destination chosen by the write stage from the final-round flag
   typedef enum logic {
      DST_LOOP = 1'b0,
      DST_EXT  = 1'b1
   } dst_sel_e;

endpackage

// File: rtl/lsp_loop_fifo.sv
module lsp_loop_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] pop_data,
   output logic             full,
   output logic             empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    level;

   // Pointer wrap: free wrap for power-of-two depths, compare otherwise
   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + AW'(1);
         assign rd_nxt = rd_ptr + AW'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   assign full     = (level == CW'(DEPTH));
   assign empty    = (level == '0);
   assign pop_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   level <= level + CW'(1);
            2'b01:   level <= level - CW'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/lsp_read_unit.sv
module lsp_read_unit
   import lsp_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter int N_ITER = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_valid,
   output logic             ext_ready,
   input  logic [WIDTH-1:0] ext_data,
   input  logic             loop_avail,
   output logic             loop_pop,
   input  logic [WIDTH-1:0] loop_data,
   input  logic             stage_ready,
   output logic             rd_fire,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_last
);
   localparam int IDX_W = $clog2(N_ITER + 1);

   logic [IDX_W-1:0] iter_q;
   logic             finished_q;
   src_sel_e         src;
   logic             src_avail;

   assign src       = (iter_q == IDX_W'(1)) ? SRC_EXT : SRC_LOOP;
   assign rd_last   = (iter_q == IDX_W'(N_ITER));
   assign src_avail = (src == SRC_EXT) ? ext_valid : loop_avail;
   assign ext_ready = !finished_q && (src == SRC_EXT) && stage_ready;
   assign loop_pop  = !finished_q && (src == SRC_LOOP) && stage_ready && loop_avail;
   assign rd_fire   = !finished_q && stage_ready && src_avail;
   assign rd_data   = (src == SRC_EXT) ? ext_data : loop_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iter_q     <= IDX_W'(1);
         finished_q <= 1'b0;
      end else if (rd_fire) begin
         if (rd_last) finished_q <= 1'b1;
         else         iter_q     <= iter_q + IDX_W'(1);
      end
   end
endmodule

// File: rtl/lsp_exec_stage.sv
module lsp_exec_stage #(
   parameter int WIDTH = 16,
   parameter int STEP  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   output logic             op_ready,
   input  logic [WIDTH-1:0] op_data,
   input  logic             op_last,
   output logic             res_valid,
   input  logic             res_ready,
   output logic [WIDTH-1:0] res_data,
   output logic             res_last
);
   logic             v_q;
   logic [WIDTH-1:0] d_q;
   logic             l_q;

   assign op_ready  = !v_q || res_ready;
   assign res_valid = v_q;
   assign res_data  = d_q;
   assign res_last  = l_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         d_q <= '0;
         l_q <= 1'b0;
      end else if (op_ready) begin
         v_q <= op_valid;
         if (op_valid) begin
            d_q <= op_data + WIDTH'(STEP);
            l_q <= op_last;
         end
      end
   end
endmodule

// File: rtl/lsp_write_unit.sv
module lsp_write_unit
   import lsp_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             res_valid,
   output logic             res_ready,
   input  logic [WIDTH-1:0] res_data,
   input  logic             res_last,
   input  logic             loop_full,
   output logic             loop_push,
   output logic [WIDTH-1:0] loop_data,
   output logic             ext_valid,
   input  logic             ext_ready,
   output logic [WIDTH-1:0] ext_data,
   output logic             run_done
);
   dst_sel_e dst;
   logic     done_q;

   assign dst       = res_last ? DST_EXT : DST_LOOP;
   assign res_ready = (dst == DST_EXT) ? ext_ready : !loop_full;
   assign loop_push = res_valid && (dst == DST_LOOP) && !loop_full;
   assign loop_data = res_data;
   assign ext_valid = res_valid && (dst == DST_EXT) && !done_q;
   assign ext_data  = res_data;
   assign run_done  = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                      done_q <= 1'b0;
      else if (ext_valid && ext_ready) done_q <= 1'b1;
   end
endmodule

// File: rtl/loopback_stream_proc.sv
module loopback_stream_proc #(
   parameter int DATA_W     = 16,
   parameter int N_ITER     = 4,
   parameter int LOOP_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              done
);
   // R10: elaboration-time parameter checks
   generate
      if (N_ITER < 1) begin : g_bad_iter
         $error("N_ITER must be at least 1");
      end
      if (LOOP_DEPTH < 2) begin : g_bad_depth
         $error("LOOP_DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic              loop_push, loop_pop, loop_full, loop_empty;
   logic [DATA_W-1:0] loop_wdata, loop_rdata;
   logic              rd_fire, rd_last, stage_ready;
   logic [DATA_W-1:0] rd_data;
   logic              res_valid, res_ready, res_last;
   logic [DATA_W-1:0] res_data;

   lsp_read_unit #(.WIDTH(DATA_W), .N_ITER(N_ITER)) u_read (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_valid  (in_valid),
      .ext_ready  (in_ready),
      .ext_data   (in_data),
      .loop_avail (!loop_empty),
      .loop_pop   (loop_pop),
      .loop_data  (loop_rdata),
      .stage_ready(stage_ready),
      .rd_fire    (rd_fire),
      .rd_data    (rd_data),
      .rd_last    (rd_last)
   );

   lsp_exec_stage #(.WIDTH(DATA_W), .STEP(1)) u_exec (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (rd_fire),
      .op_ready (stage_ready),
      .op_data  (rd_data),
      .op_last  (rd_last),
      .res_valid(res_valid),
      .res_ready(res_ready),
      .res_data (res_data),
      .res_last (res_last)
   );

   lsp_write_unit #(.WIDTH(DATA_W)) u_write (
      .clk      (clk),
      .rst_n    (rst_n),
      .res_valid(res_valid),
      .res_ready(res_ready),
      .res_data (res_data),
      .res_last (res_last),
      .loop_full(loop_full),
      .loop_push(loop_push),
      .loop_data(loop_wdata),
      .ext_valid(out_valid),
      .ext_ready(out_ready),
      .ext_data (out_data),
      .run_done (done)
   );

   lsp_loop_fifo #(.WIDTH(DATA_W), .DEPTH(LOOP_DEPTH)) u_loop (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (loop_push),
      .push_data(loop_wdata),
      .pop      (loop_pop),
      .pop_data (loop_rdata),
      .full     (loop_full),
      .empty    (loop_empty)
   );
endmodule

// File: rtl/lsp_checker.sv
module lsp_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              done,
   input logic              loop_push,
   input logic              loop_pop,
   input logic              loop_full,
   input logic              loop_empty
);
   // R3: loop channel bounds
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      loop_push |-> !loop_full);
   p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      loop_pop |-> !loop_empty);

   // R2: after the external token is taken, the input closes
   p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R6: result held under back-pressure
   p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R5: one output per run, then done
   p_single_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> (done && !out_valid));

   // R7: done is sticky and keeps the input closed
   p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
   p_closed_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !in_ready);
endmodule

bind loopback_stream_proc lsp_checker #(.DATA_W(DATA_W)) u_lsp_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .done      (done),
   .loop_push (loop_push),
   .loop_pop  (loop_pop),
   .loop_full (loop_full),
   .loop_empty(loop_empty)
);

// File: tb/loopback_stream_proc_test.sv
`timescale 1ns/1ps
module loopback_stream_proc_test;
   localparam int NA = 4;
   localparam int NB = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        out_ready = 1'b0;

   logic        in_ready_a, out_valid_a, done_a;
   logic [15:0] out_data_a;
   logic        in_ready_b, out_valid_b, done_b;
   logic [15:0] out_data_b;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   int exp_a[$];
   int exp_b[$];
   int lat_a = -1, lat_b = -1;
   bit hold_a = 0, hold_b = 0;
   logic [15:0] held_a, held_b;

   always #2 clk = ~clk;   // 250 MHz

   loopback_stream_proc #(.DATA_W(16), .N_ITER(NA), .LOOP_DEPTH(2)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_a),
      .in_data(in_data), .out_valid(out_valid_a), .out_ready(out_ready),
      .out_data(out_data_a), .done(done_a));

   loopback_stream_proc #(.DATA_W(16), .N_ITER(NB), .LOOP_DEPTH(3)) uut_n1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b),
      .in_data(in_data), .out_valid(out_valid_b), .out_ready(out_ready),
      .out_data(out_data_b), .done(done_b));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // Reference model, compared every clock at the falling edge
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         // R3: latency of the loop
         if (lat_a >= 0) begin
            lat_a++;
            if (out_valid_a) begin
               chk(lat_a == 2*NA-1, "R3 latency N=4", lat_a, 2*NA-1);
               lat_a = -1;
            end
         end
         if (lat_b >= 0) begin
            lat_b++;
            if (out_valid_b) begin
               chk(lat_b == 2*NB-1, "R8 latency N=1", lat_b, 2*NB-1);
               lat_b = -1;
            end
         end
         // R6: held result
         if (hold_a) chk(out_valid_a && out_data_a == held_a, "R6 hold N=4", int'(out_data_a), int'(held_a));
         if (hold_b) chk(out_valid_b && out_data_b == held_b, "R6 hold N=1", int'(out_data_b), int'(held_b));
         hold_a = out_valid_a && !out_ready; held_a = out_data_a;
         hold_b = out_valid_b && !out_ready; held_b = out_data_b;
         // R9: no output without an accepted token
         if (out_valid_a && exp_a.size() == 0) chk(0, "R9 spurious out N=4", 1, 0);
         if (out_valid_b && exp_b.size() == 0) chk(0, "R9 spurious out N=1", 1, 0);
         // R7: input closed while done
         if (done_a) chk(!in_ready_a, "R7 closed N=4", int'(in_ready_a), 0);
         if (done_b) chk(!in_ready_b, "R7 closed N=1", int'(in_ready_b), 0);
         // R4 / R5 / R8: results
         if (out_valid_a && out_ready && exp_a.size() > 0) begin
            chk(int'(out_data_a) == exp_a[0], "R4 result N=4", int'(out_data_a), exp_a[0]);
            void'(exp_a.pop_front());
         end
         if (out_valid_b && out_ready && exp_b.size() > 0) begin
            chk(int'(out_data_b) == exp_b[0], "R8 result N=1", int'(out_data_b), exp_b[0]);
            void'(exp_b.pop_front());
         end
         // Inputs accepted this cycle
         if (in_valid && in_ready_a) begin
            exp_a.push_back((int'(in_data) + NA) & 16'hFFFF);
            lat_a = 0;
         end
         if (in_valid && in_ready_b) begin
            exp_b.push_back((int'(in_data) + NB) & 16'hFFFF);
            lat_b = 0;
         end
      end
   end

   task automatic one_run(input logic [15:0] x, input int idle, input logic [7:0] bp);
      int n_a, n_b;
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
      exp_a.delete(); exp_b.delete();
      lat_a = -1; lat_b = -1; hold_a = 0; hold_b = 0;
      repeat (3) @(posedge clk);
      #1;
      chk(!out_valid_a && !done_a && in_ready_a, "R1 reset N=4", {out_valid_a, done_a, in_ready_a}, 1);
      chk(!out_valid_b && !done_b && in_ready_b, "R1 reset N=1", {out_valid_b, done_b, in_ready_b}, 1);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(!out_valid_a && !done_a && in_ready_a, "R1 after reset", {out_valid_a, done_a, in_ready_a}, 1);
      out_ready = bp[0];
      // R9: idle wait with no input
      for (int k = 0; k < idle; k++) begin
         @(posedge clk); #1;
         out_ready = bp[k % 8];
      end
      chk(!out_valid_a && !out_valid_b, "R9 idle", {out_valid_a, out_valid_b}, 0);
      in_valid = 1'b1; in_data = x;
      while (!in_ready_a) begin
         @(posedge clk); #1;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      for (int k = 0; k < 200 && !(done_a && done_b); k++) begin
         out_ready = bp[k % 8];
         @(posedge clk); #1;
      end
      chk(done_a && done_b, "R7 done raised", {done_a, done_b}, 3);
      chk(exp_a.size() == 0 && exp_b.size() == 0, "R5 one output", exp_a.size() + exp_b.size(), 0);
      // R2: further offers are refused
      n_a = exp_a.size(); n_b = exp_b.size();
      in_valid = 1'b1; in_data = x ^ 16'h00FF;
      repeat (5) begin
         @(posedge clk); #1;
         chk(!in_ready_a && !in_ready_b, "R2 input closed", {in_ready_a, in_ready_b}, 0);
      end
      in_valid = 1'b0;
      chk(exp_a.size() == n_a && exp_b.size() == n_b && !out_valid_a && !out_valid_b,
          "R2 no new token", exp_a.size() + exp_b.size(), n_a + n_b);
      chk(done_a && done_b, "R7 sticky", {done_a, done_b}, 3);
   endtask

   initial begin
      one_run(16'd5,     0, 8'hFF);
      one_run(16'hFFFE,  3, 8'b0101_0011);
      one_run(16'h1234,  7, 8'b1000_0001);
      one_run(16'h0000,  1, 8'h0F);
      finish_run();
   end

   always @(posedge clk) begin
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         finish_run();
      end
   end
endmodule